// File: doc/BRIEF.md
# SEC-DED Protected SRAM Port With Packed Check Storage

This block sits between a bus-side memory port and two single-port RAMs. The wide RAM holds the 32-bit data words. A second RAM, a quarter as deep, holds the 7-bit SEC-DED check codes packed four to a word, one code per byte. On every write the block computes the code for the data word. It writes the word to the data RAM and writes the code into its own byte lane of the check RAM. A byte enable protects the three neighbouring codes.

On a read both RAMs are read in the same cycle. When the raw data arrives, the block recomputes the code and forms a syndrome. It returns corrected data in that same cycle, so correction adds no wait state. It also raises a one-cycle single-error or double-error flag. Correction affects only the returned word. The stored copy stays wrong until a later write replaces it. Locations that were never written may hold any contents and may report false errors. Software can avoid this by writing zeros, with their codes, at start-up.

A two-state read tracker drives the response side. `RD_IDLE` means no response is due this cycle. `RD_RESP` means the RAMs are delivering data for a read accepted on the previous edge. The transitions are: `RD_IDLE -> RD_RESP` on an accepted read, `RD_RESP -> RD_RESP` on a back-to-back read, and `RD_RESP -> RD_IDLE` or `RD_IDLE -> RD_IDLE` when the cycle carries a write or no request.

Top module: `sram_ecc_guard`

## Requirements
- R1: The check byte for a data word `d` is laid out as follows.
  - Bits [5:0] hold the Hamming checks. Data bit i is assigned the i-th integer from 3 upward that is not a power of two (3, 5, 6, 7, 9, ..., 38). Check bit k is the XOR of every data bit whose assigned position has bit k set.
  - Bit 6 makes the XOR of all 32 data bits and bits [6:0] equal to zero.
  - Bit 7 is written as zero.
- R2: A write updates two places in the same cycle. It writes the data RAM at the word address. It writes the check RAM at the word address divided by four, with only byte lane `addr[1:0]` enabled, and leaves the other three lanes unchanged.
- R3: `rsp_valid` is high exactly in the cycle after an accepted read, which is the raw RAM read latency. Back-to-back reads produce back-to-back responses.
- R4: When the data and check byte agree, the returned data equals the stored word, both flags are low and the syndrome is zero.
- R5: If exactly one data bit is flipped, the correct word is returned and `err_single` pulses. The syndrome is `{1'b1, position}`, where position is the R1 position of the flipped bit.
- R6: If exactly one check bit is flipped, the stored data is returned unchanged and `err_single` pulses. The syndrome is `{1'b1, 1<<k}` for Hamming bit k, or `7'h40` for bit 6.
- R7: If two bits are flipped, `err_double` pulses and `err_single` stays low. The raw word is returned uncorrected. The syndrome has bit 6 clear and a nonzero low part.
- R8: A read never writes either RAM. A corrected location still holds its corrupted contents afterwards.
- R9: While `rsp_valid` is low, `rsp_rdata`, `rsp_syndrome` and both flags are zero, and the two flags are never high together.
- R10: A zero data word has an all-zero check byte, so zero-initialised memory reads back clean.
- R11: During reset and in the first cycle after it, `rsp_valid` and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Corrected read data |
| err_single | output | 1 | Single-bit error corrected |
| err_double | output | 1 | Uncorrectable error detected |
| rsp_syndrome | output | 7 | {parity mismatch, Hamming syndrome} |
| dram_en | output | 1 | Data RAM enable |
| dram_we | output | 1 | Data RAM write enable |
| dram_addr | output | ADDR_W | Data RAM address |
| dram_wdata | output | 32 | Data RAM write data |
| dram_rdata | input | 32 | Data RAM read data (one-cycle latency) |
| cram_en | output | 1 | Check RAM enable |
| cram_we | output | 1 | Check RAM write enable |
| cram_be | output | 4 | Check RAM byte enables |
| cram_addr | output | ADDR_W-2 | Check RAM address |
| cram_wdata | output | 32 | Check byte replicated on all lanes |
| cram_rdata | input | 32 | Check RAM read data (one-cycle latency) |

## Verification
The assertions check the RAM-side rules on every cycle: one-hot byte enables aimed at lane `addr[1:0]`, aligned check and data addresses, a zero top bit in each check byte, and no RAM write during a read. They also check the response timing, the quiet outputs when no response is due, and that the two flags never rise together. Only the bench scenarios can show that the codes, syndromes and corrected words have the right values. Those scenarios inject single data, single check and double flips into the bench-held RAMs and confirm that reads leave the corruption in place.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;

    localparam int DATA_W  = 32;
    localparam int HAM_W   = 6;
    localparam int CHK_W   = HAM_W + 1;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int LANE_AW = $clog2(LANES);
    localparam int MAX_POS = 38;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Codeword position of data bit idx: the idx-th non power of two from 3.
    function automatic int data_pos(input int idx);
        int n;
        n = 0;
        for (int p = 3; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // Data bits covered by Hamming check k.
    function automatic word_t cover_mask(input int k);
        word_t m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_ecc_encode.sv
module sram_ecc_encode
    import sram_ecc_pkg::*;
(
    input  word_t data_i,
    output chk_t  code_o
);

    logic [HAM_W-1:0] ham;

    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam word_t MASK = cover_mask(k);
        assign ham[k] = ^(data_i & MASK);
    end

    // Overall parity makes data plus all seven check bits even.
    assign code_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/sram_ecc_decode.sv
module sram_ecc_decode
    import sram_ecc_pkg::*;
(
    input  logic  valid_i,
    input  word_t raw_i,
    input  chk_t  stored_i,
    output word_t data_o,
    output logic  single_o,
    output logic  double_o,
    output chk_t  syndrome_o
);

    chk_t             fresh;
    logic [HAM_W-1:0] syn;
    logic             par_bad;
    logic             in_range;
    word_t            flip;

    sram_ecc_encode u_regen (
        .data_i (raw_i),
        .code_o (fresh)
    );

    assign syn      = fresh[HAM_W-1:0] ^ stored_i[HAM_W-1:0];
    assign par_bad  = (^raw_i) ^ (^stored_i);
    assign in_range = (int'(syn) <= MAX_POS);

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
        assign flip[i] = (syn == POS);
    end

    always_comb begin
        single_o   = 1'b0;
        double_o   = 1'b0;
        data_o     = '0;
        syndrome_o = '0;
        if (valid_i) begin
            single_o   = par_bad && in_range;
            double_o   = (!par_bad && (syn != '0)) || (par_bad && !in_range);
            data_o     = (par_bad && in_range) ? (raw_i ^ flip) : raw_i;
            syndrome_o = {par_bad, syn};
        end
    end

endmodule

// File: rtl/sram_ecc_lane.sv
module sram_ecc_lane
    import sram_ecc_pkg::*;
(
    input  logic [LANE_AW-1:0] wr_lane_i,
    input  logic [LANE_AW-1:0] rd_lane_i,
    input  chk_t               code_i,
    input  word_t              rd_word_i,
    output logic [LANES-1:0]   be_o,
    output word_t              wr_word_o,
    output chk_t               code_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign be_o[l]                       = (wr_lane_i == LANE_AW'(l));
        assign wr_word_o[l*LANE_W +: LANE_W] = {{(LANE_W-CHK_W){1'b0}}, code_i};
    end

    always_comb begin
        code_o = rd_word_i[rd_lane_i*LANE_W +: CHK_W];
    end

endmodule

// File: rtl/sram_ecc_guard.sv
module sram_ecc_guard
    import sram_ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              err_single,
    output logic              err_double,
    output logic [6:0]        rsp_syndrome,
    output logic              dram_en,
    output logic              dram_we,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [31:0]       dram_wdata,
    input  logic [31:0]       dram_rdata,
    output logic              cram_en,
    output logic              cram_we,
    output logic [3:0]        cram_be,
    output logic [ADDR_W-3:0] cram_addr,
    output logic [31:0]       cram_wdata,
    input  logic [31:0]       cram_rdata
);

    localparam int CADDR_W = ADDR_W - LANE_AW;

    rd_state_e          state_q, state_d;
    logic [LANE_AW-1:0] lane_q;
    logic               rd_req;
    logic               resp_now;
    chk_t               wr_code;
    chk_t               rd_code;

    assign rd_req = req_valid && !req_write;

    // State register and read lane capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) lane_q <= req_addr[LANE_AW-1:0];
        end
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // Output decode of the state.
    always_comb begin
        unique case (state_q)
            RD_IDLE: resp_now = 1'b0;
            RD_RESP: resp_now = 1'b1;
            default: resp_now = 1'b0;
        endcase
    end

    assign rsp_valid = resp_now;

    // RAM-side request fan-out.
    assign dram_en    = req_valid;
    assign dram_we    = req_valid && req_write;
    assign dram_addr  = req_addr;
    assign dram_wdata = req_wdata;
    assign cram_en    = req_valid;
    assign cram_we    = req_valid && req_write;
    assign cram_addr  = req_addr[ADDR_W-1 -: CADDR_W];

    sram_ecc_encode u_enc (
        .data_i (req_wdata),
        .code_o (wr_code)
    );

    sram_ecc_lane u_lane (
        .wr_lane_i (req_addr[LANE_AW-1:0]),
        .rd_lane_i (lane_q),
        .code_i    (wr_code),
        .rd_word_i (cram_rdata),
        .be_o      (cram_be),
        .wr_word_o (cram_wdata),
        .code_o    (rd_code)
    );

    sram_ecc_decode u_dec (
        .valid_i    (resp_now),
        .raw_i      (dram_rdata),
        .stored_i   (rd_code),
        .data_o     (rsp_rdata),
        .single_o   (err_single),
        .double_o   (err_double),
        .syndrome_o (rsp_syndrome)
    );

endmodule

// File: rtl/sram_ecc_guard_chk.sv
module sram_ecc_guard_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              err_single,
    input logic              err_double,
    input logic [6:0]        rsp_syndrome,
    input logic              dram_en,
    input logic              dram_we,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              cram_en,
    input logic              cram_we,
    input logic [3:0]        cram_be,
    input logic [ADDR_W-3:0] cram_addr,
    input logic [31:0]       cram_wdata
);

    p_top_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> ((cram_wdata & 32'h8080_8080) == 32'h0));

    p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> ($countones(cram_be) == 1 && cram_be[dram_addr[1:0]]));

    p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cram_en && dram_en) |-> (cram_addr == dram_addr[ADDR_W-1:2]));

    p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_resp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));

    p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (!dram_we && !cram_we));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!err_single && !err_double && rsp_syndrome == 7'h0 && rsp_rdata == 32'h0));

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !err_single && !err_double));

endmodule

bind sram_ecc_guard sram_ecc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sram_ecc_guard_tb_top.sv
module sram_ecc_guard_tb_top;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 10; // 20 time units per clock: 50 MHz in ns

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, err_single, err_double;
    logic [31:0]   rsp_rdata;
    logic [6:0]    rsp_syndrome;
    logic          dram_en, dram_we, cram_en, cram_we;
    logic [AW-1:0] dram_addr;
    logic [AW-3:0] cram_addr;
    logic [3:0]    cram_be;
    logic [31:0]   dram_wdata, dram_rdata, cram_wdata, cram_rdata;

    logic [31:0] mem_d [DEPTH];
    logic [31:0] mem_c [DEPTH/4];
    logic [31:0] shadow [DEPTH];
    bit          written [DEPTH];

    int total = 0;
    int bad   = 0;

    always #(HALF) clk = ~clk;

    // Behavioural RAMs, one-cycle read latency.
    always @(posedge clk) begin
        if (dram_en) begin
            if (dram_we) mem_d[dram_addr] <= dram_wdata;
            dram_rdata <= mem_d[dram_addr];
        end
        if (cram_en) begin
            for (int l = 0; l < 4; l++)
                if (cram_we && cram_be[l]) mem_c[cram_addr][l*8 +: 8] <= cram_wdata[l*8 +: 8];
            cram_rdata <= mem_c[cram_addr];
        end
    end

    sram_ecc_guard #(.ADDR_W(AW)) dut_i (.*);

    function automatic int bpos(input int i);
        int p = 2;
        int n = -1;
        while (n < i) begin
            p++;
            if (p != 4 && p != 8 && p != 16 && p != 32) n++;
        end
        return p;
    endfunction

    function automatic logic [6:0] bcode(input logic [31:0] d);
        logic [5:0] h = '0;
        for (int i = 0; i < 32; i++) if (d[i]) h ^= 6'(bpos(i));
        return {(^d) ^ (^h), h};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        shadow[a]  = d;
        written[a] = 1'b1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d,
                           output logic s, output logic dd, output logic [6:0] syn,
                           output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        v = rsp_valid; d = rsp_rdata; s = err_single; dd = err_double; syn = rsp_syndrome;
        req_valid = 1'b0;
    endtask

    logic [31:0] rd, old_c;
    logic        s1, d2, vv;
    logic [6:0]  sy;

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mem_d[i] = $urandom;
        for (int i = 0; i < DEPTH/4; i++) mem_c[i] = $urandom;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !err_single && !err_double, "R11", "reset outputs",
            {rsp_valid, err_single, err_double}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !err_single && !err_double, "R11", "after reset",
            {rsp_valid, err_single, err_double}, 0);

        // R1/R2: code byte layout and lane isolation
        for (int l = 0; l < 4; l++) begin
            logic [AW-1:0] a;
            logic [31:0]   dv;
            a = AW'(40 + l);
            dv = $urandom;
            old_c = mem_c[a >> 2];
            do_write(a, dv);
            chk(mem_c[a >> 2][l*8 +: 8] == {1'b0, bcode(dv)}, "R1", "check byte",
                mem_c[a >> 2][l*8 +: 8], {1'b0, bcode(dv)});
            for (int o = 0; o < 4; o++)
                if (o != l)
                    chk(mem_c[a >> 2][o*8 +: 8] == old_c[o*8 +: 8], "R2", "neighbour lane",
                        mem_c[a >> 2][o*8 +: 8], old_c[o*8 +: 8]);
            chk(mem_d[a] == dv, "R2", "data RAM", mem_d[a], dv);
        end

        // R10: zero word, zero code, clean read
        do_write(AW'(7), 32'h0);
        chk(mem_c[1][31:24] == 8'h0, "R10", "zero code", mem_c[1][31:24], 0);
        do_read(AW'(7), rd, s1, d2, sy, vv);
        chk(vv && rd == 0 && !s1 && !d2 && sy == 0, "R10", "zero read", {rd, s1, d2, sy}, 0);

        // R3: back-to-back reads, then quiet
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(40);
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == shadow[40], "R3", "b2b first", rsp_rdata, shadow[40]);
        req_addr = AW'(41);
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == shadow[41], "R3", "b2b second", rsp_rdata, shadow[41]);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid && rsp_rdata == 0 && !err_single && !err_double && rsp_syndrome == 0,
            "R9", "quiet idle", {rsp_valid, rsp_rdata}, 0);

        // Directed: overall parity bit flip (R6)
        mem_c[40 >> 2][6] = ~mem_c[40 >> 2][6];
        do_read(AW'(40), rd, s1, d2, sy, vv);
        chk(rd == shadow[40] && s1 && !d2 && sy == 7'h40, "R6", "parity bit flip",
            {rd, s1, d2, sy}, {shadow[40], 2'b10, 7'h40});
        do_write(AW'(40), shadow[40]);

        // Constrained random mix
        for (int it = 0; it < 600; it++) begin
            logic [AW-1:0] a;
            int            op;
            a  = AW'($urandom % 64);
            op = $urandom % 5;
            if (op < 2 || !written[a]) begin
                do_write(a, $urandom);
            end else if (op == 2) begin
                do_read(a, rd, s1, d2, sy, vv);
                chk(vv && rd == shadow[a] && !s1 && !d2 && sy == 0, "R4", "clean read",
                    {rd, s1, d2, sy}, {shadow[a], 9'h0});
            end else if (op == 3) begin
                int b = $urandom % 32;
                mem_d[a][b] = ~mem_d[a][b];
                do_read(a, rd, s1, d2, sy, vv);
                chk(rd == shadow[a] && s1 && !d2 && sy == {1'b1, 6'(bpos(b))}, "R5",
                    "data flip", {rd, s1, d2, sy}, {shadow[a], 2'b10, 1'b1, 6'(bpos(b))});
                chk(mem_d[a] == (shadow[a] ^ (32'h1 << b)), "R8", "stored stays wrong",
                    mem_d[a], shadow[a] ^ (32'h1 << b));
                if ($urandom % 2 == 0) begin
                    int k = $urandom % 6;
                    mem_d[a][b] = ~mem_d[a][b];
                    mem_c[a >> 2][a[1:0]*8 + k] = ~mem_c[a >> 2][a[1:0]*8 + k];
                    do_read(a, rd, s1, d2, sy, vv);
                    chk(rd == shadow[a] && s1 && !d2 && sy == {1'b1, 6'(1 << k)}, "R6",
                        "check flip", {rd, s1, d2, sy}, {shadow[a], 2'b10, 1'b1, 6'(1 << k)});
                end
                do_write(a, shadow[a]);
            end else begin
                int b = $urandom % 32;
                int c = (b + 1 + ($urandom % 31)) % 32;
                logic [31:0] raw;
                raw = shadow[a] ^ (32'h1 << b) ^ (32'h1 << c);
                mem_d[a] = raw;
                do_read(a, rd, s1, d2, sy, vv);
                chk(rd == raw && !s1 && d2 && !sy[6] && sy[5:0] == 6'(bpos(b) ^ bpos(c)),
                    "R7", "double flip", {rd, s1, d2, sy},
                    {raw, 2'b01, 1'b0, 6'(bpos(b) ^ bpos(c))});
                do_write(a, shadow[a]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(2 * HALF * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule